// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves one active-low external interrupt input of a small microcontroller. The pin is resynchronised to the system clock, and the block watches the synchronised level for high-to-low transitions. Each transition sets a request latch. A control bit picks the sensitivity. In edge mode only transitions raise a request. In edge-and-level mode a pin held low also keeps the request asserted.

The latch clears on three events: the CPU's vector-fetch acknowledge strobe, a software write that sets the acknowledge bit, or reset. A mask bit stops the pending request from reaching the interrupt priority logic. The latch keeps its state while masked, so a masked request is not lost. The synchronised pin level is also exported so that branch-on-pin-level instructions can test it.

Software sees a single 8-bit status/control byte through a write strobe and a continuous read-back. The fields are a read-only pending flag, a write-only acknowledge bit, a mask bit and a sensitivity-mode bit.

Top module: `xint_pin_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `irq_req` is 0 and `pin_level` is 1 while the pin is high.
- R2: `pin_level` follows `pin_n` two clock edges after the pin changes, when the default synchroniser depth of 2 is used.
- R3: A high-to-low change of the pin sets the pending flag (byte bit 3). The flag reads 1 after the third rising clock edge that follows the change. In edge mode (bit 0 = 0), a pin held low raises no new request once the flag has been acknowledged.
- R4: A one-cycle `vec_ack` pulse clears the pending latch at the next edge.
- R5: A write whose data bit 2 is 1 acknowledges the latch in the same way as `vec_ack`. Bit 2 always reads 0.
- R6: In edge-and-level mode (bit 0 = 1), the pending flag stays 1 while the pin is low, even after an acknowledge. It clears once both an acknowledge has occurred and the pin has returned high, in either order.
- R7: While the mask bit (byte bit 1) is 1, `irq_req` is 0 and the pending flag still reflects the latched request. Clearing the mask presents the held request on `irq_req`.
- R8: When a new falling edge and an acknowledge meet in the same cycle, the latch stays set.
- R9: Bits 7..4 always read 0. Bits 1 and 0 are read/write. Writing bit 3 has no effect on the flag.
- R10: Reset clears the latch and the mode bit, so no request remains even while the pin is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Raw active-low interrupt pin, asynchronous |
| vec_ack | input | 1 | One-cycle vector-fetch acknowledge strobe |
| reg_wr | input | 1 | Write strobe for the status/control byte |
| reg_wdata | input | 8 | Write data for the status/control byte |
| reg_rdata | output | 8 | Read-back of the status/control byte |
| irq_req | output | 1 | Masked request to the priority logic |
| pin_level | output | 1 | Synchronised pin level for branch-on-pin instructions |

## Verification
Two events can land in the same clock cycle: an acknowledge that clears the latch and a fresh falling edge that sets it. The bench provokes this on purpose. It lowers the pin, waits exactly two edges so that the detected edge is live, and then pulses `vec_ack` in that cycle. It judges the result by reading the pending flag one edge later, which must still be 1. The random phase also lets software acknowledges, vector strobes and pin toggles overlap freely. Every cycle is compared against a bench-side cycle model written from the requirements.

// File: rtl/xint_pkg.sv
package xint_pkg;
   // Status/control byte field positions (software-visible layout)
   localparam int unsigned BIT_MODE  = 0;
   localparam int unsigned BIT_MASK  = 1;
   localparam int unsigned BIT_ACK   = 2;
   localparam int unsigned BIT_FLAG  = 3;
   localparam int unsigned USED_BITS = 4;

   typedef enum logic {
      SENSE_EDGE       = 1'b0,
      SENSE_EDGE_LEVEL = 1'b1
   } sense_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic fall
);
   initial begin
      if (STAGES < 2) $error("xint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign fall  = prev_q & ~chain_q[STAGES-1];

   AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !prev_q); // R3
endmodule

// File: rtl/xint_req_latch.sv
module xint_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic ack,
   input  logic level_sense,
   input  logic level,
   output logic latch_q,
   output logic pending
);
   // A new edge outranks a simultaneous acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   latch_q <= 1'b0;
      else if (fall) latch_q <= 1'b1;
      else if (ack)  latch_q <= 1'b0;
   end

   assign pending = latch_q | (level_sense & ~level);

   AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> latch_q); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !fall) |=> !latch_q); // R4
   AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && fall) |=> latch_q); // R8
endmodule

// File: rtl/xint_ctrl_reg.sv
module xint_ctrl_reg
   import xint_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter bit          HAS_LEVEL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         flag,
   output logic [W-1:0] rdata,
   output logic         mask_q,
   output logic         mode_q,
   output logic         sw_ack
);
   initial begin
      if (W < USED_BITS) $error("xint_ctrl_reg: W too small for the field layout");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= 1'b0;
      else if (wr) mask_q <= wdata[BIT_MASK];
   end

   generate
      if (HAS_LEVEL) begin : g_mode
         sense_e mode_e;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  mode_e <= SENSE_EDGE;
            else if (wr) mode_e <= sense_e'(wdata[BIT_MODE]);
         end
         assign mode_q = (mode_e == SENSE_EDGE_LEVEL);
      end else begin : g_no_mode
         assign mode_q = 1'b0;
      end
   endgenerate

   assign sw_ack = wr & wdata[BIT_ACK];

   always_comb begin
      rdata           = '0;
      rdata[BIT_FLAG] = flag;
      rdata[BIT_MASK] = mask_q;
      rdata[BIT_MODE] = mode_q;
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[W-1:BIT_FLAG], (HAS_LEVEL ? 1'b0 : wdata[BIT_MODE])};

   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (mask_q == $past(wdata[BIT_MASK]))); // R9
endmodule

// File: rtl/xint_pin_ctrl.sv
module xint_pin_ctrl
   import xint_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 8,
   parameter bit          HAS_LEVEL   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_n,
   input  logic             vec_ack,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_req,
   output logic             pin_level
);
   logic fall, latch_q, pending, mask_q, mode_q, sw_ack, ack;

   xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_n), .level(pin_level), .fall(fall));

   assign ack = vec_ack | sw_ack;

   xint_req_latch u_latch (
      .clk(clk), .rst_n(rst_n), .fall(fall), .ack(ack),
      .level_sense(mode_q), .level(pin_level),
      .latch_q(latch_q), .pending(pending));

   xint_ctrl_reg #(.W(REG_W), .HAS_LEVEL(HAS_LEVEL)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .flag(pending), .rdata(reg_rdata), .mask_q(mask_q),
      .mode_q(mode_q), .sw_ack(sw_ack));

   assign irq_req = pending & ~mask_q;

   AST_SW_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[BIT_ACK] && !fall) |=> !latch_q); // R5
   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[BIT_MODE] && !pin_level) |-> reg_rdata[BIT_FLAG]); // R6
   AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && latch_q && !ack) |=> latch_q); // R7
   AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:USED_BITS] == '0); // R9
endmodule

// File: tb/xint_pin_ctrl_bench.sv
module xint_pin_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_n = 1'b1;
   logic       vec_ack = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_req, pin_level;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #10 clk = ~clk; // 50 MHz

   xint_pin_ctrl u_xint_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .vec_ack(vec_ack),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .pin_level(pin_level));

   // Cycle model written from the requirements
   logic m_s1, m_s2, m_prev, m_latch, m_mode, m_mask;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
         m_latch <= 1'b0; m_mode <= 1'b0; m_mask <= 1'b0;
      end else begin
         m_s1 <= pin_n; m_s2 <= m_s1; m_prev <= m_s2;
         if (m_prev && !m_s2) m_latch <= 1'b1;
         else if (vec_ack || (reg_wr && reg_wdata[2])) m_latch <= 1'b0;
         if (reg_wr) begin m_mode <= reg_wdata[0]; m_mask <= reg_wdata[1]; end
      end
   end

   function automatic logic exp_flag(input logic l, input logic md, input logic s);
      return l | (md & ~s);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Continuous comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic f;
         f = exp_flag(m_latch, m_mode, m_s2);
         check({cur_req, " R2 level"}, {7'd0, pin_level}, {7'd0, m_s2});
         check({cur_req, " R9 byte"}, reg_rdata, {4'd0, f, 1'b0, m_mask, m_mode});
         check({cur_req, " R7 irq"}, {7'd0, irq_req}, {7'd0, f & ~m_mask});
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      reg_wr = 1'b1; reg_wdata = d; step(1); reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      step(1);
      do_reset();
      cur_req = "R1";
      check("R1 reset byte", reg_rdata, 8'h00);
      check("R1 reset irq", {7'd0, irq_req}, 8'h00);
      check("R1 reset level", {7'd0, pin_level}, 8'h01);

      // R3 edge mode: flag set after third edge
      cur_req = "R3";
      pin_n = 1'b0; step(2);
      check("R3 flag not yet", {4'd0, reg_rdata[3], 3'd0}, 8'h00);
      step(1);
      check("R3 flag set", {4'd0, reg_rdata[3], 3'd0}, 8'h08);
      cur_req = "R4";
      vec_ack = 1'b1; step(1); vec_ack = 1'b0;
      check("R4 vec ack clears", reg_rdata, 8'h00);
      step(4);
      check("R3 held low no retrigger", reg_rdata, 8'h00);
      pin_n = 1'b1; step(4);

      // R5 software ack
      cur_req = "R5";
      pin_n = 1'b0; step(4);
      wr(8'h04);
      check("R5 sw ack clears, bit2 reads 0", reg_rdata, 8'h00);
      pin_n = 1'b1; step(4);

      // R8 collision: ack while edge detected
      cur_req = "R8";
      pin_n = 1'b0; step(2);
      vec_ack = 1'b1; step(1); vec_ack = 1'b0;
      check("R8 edge beats ack", {4'd0, reg_rdata[3], 3'd0}, 8'h08);
      vec_ack = 1'b1; step(1); vec_ack = 1'b0;
      pin_n = 1'b1; step(4);

      // R6 level mode, ack before pin high
      cur_req = "R6";
      wr(8'h01);
      pin_n = 1'b0; step(4);
      wr(8'h05);
      check("R6 still pending while low", reg_rdata, 8'h09);
      pin_n = 1'b1; step(2);
      check("R6 clears after ack then high", reg_rdata, 8'h01);
      // ack after pin high
      pin_n = 1'b0; step(4); pin_n = 1'b1; step(3);
      check("R6 pending until ack", reg_rdata, 8'h09);
      vec_ack = 1'b1; step(1); vec_ack = 1'b0;
      check("R6 clears after high then ack", reg_rdata, 8'h01);

      // R7 mask holds request
      cur_req = "R7";
      wr(8'h02);
      pin_n = 1'b0; step(4);
      check("R7 masked irq low", {7'd0, irq_req}, 8'h00);
      check("R7 flag kept", reg_rdata, 8'h0A);
      wr(8'h08);
      check("R9 flag write ignored, R7 unmask presents", {7'd0, irq_req}, 8'h01);
      wr(8'hF0);
      check("R9 high bits read 0", reg_rdata, 8'h08);

      // R10 reset clears latch and mode with pin low
      cur_req = "R10";
      wr(8'h01);
      step(2);
      do_reset();
      check("R10 reset with pin low", reg_rdata, 8'h00);
      check("R10 no request", {7'd0, irq_req}, 8'h00);
      pin_n = 1'b1; step(4);

      // Random phase
      cur_req = "RND";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 5) == 0) pin_n = ~pin_n;
         vec_ack = ($urandom_range(0, 7) == 0);
         reg_wr = ($urandom_range(0, 5) == 0);
         reg_wdata = 8'($urandom);
         step(1);
      end
      vec_ack = 1'b0; reg_wr = 1'b0;
      step(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule